// File: doc/BRIEF.md
# Dual-Mode Local Destination Filter

This block sits at the cell ingress of a switch chip that owns two consecutive output ports out of a larger system. A cell header carries a 64-bit routing field. Each cell is filtered either as unicast or as multicast, chosen per cell by a mode select:

- In unicast mode the field is read as a binary destination port number.
- In multicast mode the field is read as a bitmap over every port in the system.

The chip is configured with the index of its first owned port. The filter decides which of its two local ports wants a copy of the cell.

The result is a two-bit local destination mask and an accept flag. Both are registered and appear one clock after the header-valid strobe. When both mask bits are set, the downstream queueing logic makes one independent copy for each port. A base index that leaves no room for two ports inside the field is an illegal configuration, and every cell is then rejected.

Top module: `cell_dest_filter`

## Requirements
- R1: After reset, and until the first header is filtered, the mask and accept outputs are zero.
- R2: In unicast mode (mode input 0), a header whose 64-bit field equals the base index sets mask bit 0, and a field equal to base+1 sets mask bit 1. The result appears on the clock edge after the strobe.
- R3: In unicast mode at most one mask bit is ever set. A field value that is neither base nor base+1 yields a zero mask, including values of 64 or more.
- R4: In multicast mode (mode input 1), mask bit i equals bit (base+i) of the routing field, for i = 0 and 1. All other field bits have no effect.
- R5: The accept output is one exactly when at least one mask bit is one.
- R6: In multicast mode, when both owned bits are set, both mask bits are one, so a copy is requested toward each local port.
- R7: A base index above 62 is illegal. With an illegal base, mask and accept are zero in both modes for any field value.
- R8: In a cycle with the header-valid strobe low, the outputs on the following edge are zero, whatever the field, mode and base inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Header-valid strobe, one cycle per cell |
| route_fld | input | 64 | Routing field from the cell header |
| mode_sel | input | 1 | 0 = unicast port number, 1 = multicast bitmap |
| base_idx | input | 7 | Index of the first of the two owned ports |
| dest_mask | output | 2 | Local destination mask, bit i = port base+i |
| dest_accept | output | 1 | Cell accepted into this chip |

## Verification
The bench uses the default build: a 64-bit field, two local ports and a 7-bit base index. The 7-bit index can carry values from 63 up to 127, so illegal configurations can be driven, along with the highest legal base of 62, where the owned bits are the two top bits of the field. Random bases and fields are drawn near the owned ports so that unicast hits and near misses occur often. Directed cases cover the field edges and unicast values of 64 or more.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
    localparam int LOCAL_N = 2;

    typedef enum logic {
        MODE_UNI   = 1'b0,
        MODE_MULTI = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic [LOCAL_N-1:0] mask;
        logic               accept;
    } filt_out_t;
endpackage

// File: rtl/uni_port_match.sv
module uni_port_match #(
    parameter int FIELD_W = 64,
    parameter int BASE_W  = 7,
    parameter int LOCAL_N = 2
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic [BASE_W-1:0]  base,
    output logic [LOCAL_N-1:0] hit
);
    logic [FIELD_W-1:0] base_ext;

    always_comb base_ext = FIELD_W'(base);

    for (genvar gi = 0; gi < LOCAL_N; gi++) begin : g_cmp
        always_comb hit[gi] = (fld == base_ext + FIELD_W'(gi));
    end
endmodule

// File: rtl/multi_bit_pick.sv
module multi_bit_pick #(
    parameter int FIELD_W = 64,
    parameter int BASE_W  = 7,
    parameter int LOCAL_N = 2
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic [BASE_W-1:0]  base,
    output logic [LOCAL_N-1:0] hit
);
    logic [FIELD_W-1:0] shifted;

    always_comb shifted = fld >> base;

    for (genvar gi = 0; gi < LOCAL_N; gi++) begin : g_pick
        always_comb hit[gi] = shifted[gi];
    end
endmodule

// File: rtl/cell_dest_filter.sv
module cell_dest_filter
    import addr_filt_pkg::*;
#(
    parameter int FIELD_W = 64,
    parameter int BASE_W  = $clog2(FIELD_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_vld,
    input  logic [FIELD_W-1:0] route_fld,
    input  logic               mode_sel,
    input  logic [BASE_W-1:0]  base_idx,
    output logic [LOCAL_N-1:0] dest_mask,
    output logic               dest_accept
);
    localparam int MAX_BASE = FIELD_W - LOCAL_N;

    route_mode_e        mode;
    logic [LOCAL_N-1:0] uni_hit;
    logic [LOCAL_N-1:0] multi_hit;
    logic               base_ok;
    filt_out_t          st_d, st_q;

    always_comb mode = route_mode_e'(mode_sel);

    uni_port_match #(
        .FIELD_W (FIELD_W),
        .BASE_W  (BASE_W),
        .LOCAL_N (LOCAL_N)
    ) uni_i (
        .fld  (route_fld),
        .base (base_idx),
        .hit  (uni_hit)
    );

    multi_bit_pick #(
        .FIELD_W (FIELD_W),
        .BASE_W  (BASE_W),
        .LOCAL_N (LOCAL_N)
    ) multi_i (
        .fld  (route_fld),
        .base (base_idx),
        .hit  (multi_hit)
    );

    always_comb begin
        base_ok = (int'(base_idx) <= MAX_BASE);
        st_d = '0;
        if (hdr_vld && base_ok) begin
            st_d.mask = (mode == MODE_MULTI) ? multi_hit : uni_hit;
        end
        st_d.accept = |st_d.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dest_mask   = st_q.mask;
    assign dest_accept = st_q.accept;

    // R3: a unicast header never flags more than one local port
    p_uni_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && !mode_sel) |=> $onehot0(dest_mask));

    // R5: accept tracks the registered mask
    p_accept_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dest_accept == (|dest_mask));

    // R7: illegal base rejects every cell
    p_bad_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(base_idx) > MAX_BASE) |=> (dest_mask == '0 && !dest_accept));

    // R8: no strobe, no destination
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld |=> (dest_mask == '0));

    // R4: multicast reports the owned bitmap bits
    p_multi_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && mode_sel && int'(base_idx) <= MAX_BASE)
        |=> dest_mask == $past(multi_hit));
endmodule

// File: tb/cell_dest_filter_tb.sv
module cell_dest_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 64;
    localparam int BW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_vld = 1'b0;
    logic [FW-1:0] route_fld = '0;
    logic          mode_sel = 1'b0;
    logic [BW-1:0] base_idx = '0;
    logic [1:0]    dest_mask;
    logic          dest_accept;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_dest_filter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdr_vld     (hdr_vld),
        .route_fld   (route_fld),
        .mode_sel    (mode_sel),
        .base_idx    (base_idx),
        .dest_mask   (dest_mask),
        .dest_accept (dest_accept)
    );

    function automatic logic [1:0] ref_mask(input logic v, input logic m,
                                            input logic [FW-1:0] f,
                                            input logic [BW-1:0] b);
        logic [1:0] r = 2'b00;
        if (!v || int'(b) > 62) return 2'b00;          // R8, R7
        for (int i = 0; i < 2; i++) begin
            if (m) r[i] = f[int'(b) + i];             // R4
            else   r[i] = (f == FW'(int'(b) + i));    // R2, R3
        end
        return r;
    endfunction

    function automatic string req_tag(input logic v, input logic m,
                                      input logic [BW-1:0] b, input logic [1:0] e);
        if (!v) return "R8";
        if (int'(b) > 62) return "R7";
        if (m && e == 2'b11) return "R6";
        if (m) return "R4";
        if (e == 2'b00) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [1:0] exp_m);
        n_cmp++;
        if (dest_mask !== exp_m) begin
            n_bad++;
            $display("FAIL %s mask actual=%b expected=%b", tag, dest_mask, exp_m);
        end
        n_cmp++;
        if (dest_accept !== (|exp_m)) begin
            n_bad++;
            $display("FAIL R5 (%s) accept actual=%b expected=%b", tag, dest_accept, |exp_m);
        end
    endtask

    // drive at negedge, result checked at the following negedge
    task automatic apply(input logic v, input logic m, input logic [FW-1:0] f,
                         input logic [BW-1:0] b);
        logic [1:0] e;
        hdr_vld = v; mode_sel = m; route_fld = f; base_idx = b;
        e = ref_mask(v, m, f, b);
        @(negedge clk);
        check(req_tag(v, m, b, e), e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'b00);

        apply(1, 0, 64'd10, 7'd10);             // R2 bit 0
        apply(1, 0, 64'd11, 7'd10);             // R2 bit 1
        apply(1, 0, 64'd12, 7'd10);             // R3 miss
        apply(1, 0, 64'd9,  7'd10);             // R3 miss below
        apply(1, 0, 64'd63, 7'd62);             // R2 top port
        apply(1, 0, 64'd64, 7'd63);             // R7 illegal
        apply(1, 0, (64'd1 << 40) | 64'd10, 7'd10); // R3 high bits
        apply(1, 1, 64'h3 << 20, 7'd20);        // R6 both
        apply(1, 1, ~(64'h3 << 20), 7'd20);     // R4 others ignored
        apply(1, 1, 64'hC000_0000_0000_0000, 7'd62); // R6 top edge
        apply(1, 1, '1, 7'd63);                 // R7 illegal multicast
        apply(1, 1, '1, 7'd127);                // R7
        apply(0, 1, '1, 7'd0);                  // R8 idle
        apply(1, 1, 64'h1, 7'd0);               // R4 bit 0 only
        apply(0, 0, 64'd0, 7'd0);               // R8 unicast idle

        void'($urandom(32'd20240607));
        for (int k = 0; k < 3000; k++) begin
            logic [BW-1:0] b;
            logic [FW-1:0] f;
            logic m;
            logic v;
            b = ($urandom % 8 == 0) ? BW'($urandom % 128) : BW'($urandom % 63);
            m = $urandom % 2;
            v = ($urandom % 6) != 0;
            if (!m && ($urandom % 4) != 0)
                f = FW'(int'(b) + int'($urandom % 4) - 1);
            else
                f = {$urandom, $urandom};
            apply(v, m, f, b);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule